// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

This block holds the sticky event flags of one channel of a 16-bit timer. Each general register of the channel has one flag. The mode bit of that register decides what sets the flag. In compare mode the flag sets when the running counter equals the register. In capture mode a capture strobe copies the counter into the register and sets the flag on the same clock edge. The block also holds the general registers themselves, which software loads through a simple write port.

Software can clear a flag only with a handshake. It first reads the status register and sees the flag as 1, and then it writes 0 to that bit. A data-transfer controller that services a flag's interrupt also clears the flag, unless its keep-flag control is set for that transfer. Each interrupt request is the flag gated by its own enable bit. A parameter removes flag C, the flag at bit position 2, from channel variants that lack it. On those variants the bit always reads 0.

Top module: `tmr_cc_flags`

## Requirements
- R1: After reset all flags, all interrupt requests and all general registers are 0.
- R2: A general register whose mode bit is 0 (compare) sets its flag on the clock edge that ends a cycle in which the counter equals that register. The flag is visible one cycle later.
- R3: A general register whose mode bit is 1 (capture) loads the counter value and sets its flag on the same edge when its capture strobe is high. In capture mode an equal counter does not set the flag. A strobe in compare mode neither loads nor sets.
- R4: A write with bit i equal to 0 clears flag i when the last status read before that write returned flag i as 1.
- R5: A write of 0 clears nothing for a flag that the previous read did not return as 1. Each write uses up the read qualifiers, so a second write needs a fresh read.
- R6: Writing 1 to a flag bit never sets the flag and never clears it.
- R7: A transfer acknowledge for flag i clears the flag when the keep-flag input is 0. The flag stays set when the keep-flag input is 1.
- R8: When a set event and a clear event for a flag happen in the same cycle, the flag ends set.
- R9: Interrupt request i is high exactly when flag i and enable i are both 1. This is combinational.
- R10: With HAS_FLAG_C = 0, bit 2 always reads 0, ignores captures, compares and writes, and never raises an interrupt request.
- R11: In the status register, flag A sits at bit 0, flag B at bit 1 and flag C at bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current timer counter value |
| ic_mode | input | NUM_GR | Per-register mode bit: 1 = capture, 0 = compare |
| cap_stb | input | NUM_GR | Per-register capture strobe |
| gr_we | input | 1 | General register write enable |
| gr_sel | input | SEL_W | Index of the general register to write |
| gr_wdata | input | CNT_W | General register write data |
| gr_q | output | NUM_GR*CNT_W | General register contents, register i at slice i |
| sr_rd | input | 1 | Status read strobe (arms the per-flag qualifiers) |
| sr_wr | input | 1 | Status write strobe |
| sr_wdata | input | NUM_GR | Status write data |
| sr_rdata | output | NUM_GR | Status flags, flag i at bit i |
| xfer_ack | input | NUM_GR | Transfer controller acknowledge, one per flag |
| xfer_keep | input | 1 | Keep-flag control of the current transfer |
| irq_en | input | NUM_GR | Per-flag interrupt enable |
| irq | output | NUM_GR | Per-flag interrupt request |

## Verification
The embedded properties watch the per-cycle rules on every cycle. They check that a set event always leaves the flag high on the next cycle, even when a clear arrives with it. They check that a flag never rises without a set event and never falls without a qualified clear. They also check that a compare match or a capture always reaches the flag and the register, and that a status write always drops the read qualifiers. Only the directed scenarios can show the handshake as a sequence. These cover a read that returned 0 followed by a write of 0, the qualifier being used up across two writes, the keep-flag input blocking a transfer clear, and the bit positions seen at the ports. They also compare a channel variant without flag C against a full one on the same stimulus.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

    // Bit position of the optional third flag.
    localparam int FLAG_C_POS = 2;

    typedef enum logic {
        GR_COMPARE = 1'b0,
        GR_CAPTURE = 1'b1
    } gr_mode_e;

    // Events that reach a single flag in one cycle.
    typedef struct packed {
        logic set_ev;
        logic clr_sw;
        logic clr_xfer;
    } flag_evt_t;

    // Whether flag idx is implemented on a channel variant.
    function automatic bit flag_present(int idx, bit has_c);
        return !(idx == FLAG_C_POS && !has_c);
    endfunction

    // Next-state rule for a sticky flag: set dominates clear.
    function automatic logic flag_next(logic cur, flag_evt_t ev);
        if (ev.set_ev)
            return 1'b1;
        else if (ev.clr_sw || ev.clr_xfer)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/tmr_gr_bank.sv
module tmr_gr_bank
    import tmr_flag_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_GR = 3,
    parameter int SEL_W  = (NUM_GR > 1) ? $clog2(NUM_GR) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          cnt_val,
    input  logic [NUM_GR-1:0]         ic_mode,
    input  logic [NUM_GR-1:0]         cap_stb,
    input  logic                      gr_we,
    input  logic [SEL_W-1:0]          gr_sel,
    input  logic [CNT_W-1:0]          gr_wdata,
    output logic [NUM_GR*CNT_W-1:0]   gr_q,
    output logic [NUM_GR-1:0]         cap_hit,
    output logic [NUM_GR-1:0]         cmp_hit
);

    for (genvar i = 0; i < NUM_GR; i++) begin : g_reg
        logic [CNT_W-1:0] gr_r;
        gr_mode_e         mode;

        assign mode = gr_mode_e'(ic_mode[i]);
        assign cap_hit[i] = (mode == GR_CAPTURE) && cap_stb[i];
        assign cmp_hit[i] = (mode == GR_COMPARE) && (cnt_val == gr_r);

        // A capture has priority over a software load of the same register.
        always_ff @(posedge clk) begin
            if (rst)
                gr_r <= '0;
            else if (cap_hit[i])
                gr_r <= cnt_val;
            else if (gr_we && (gr_sel == SEL_W'(i)))
                gr_r <= gr_wdata;
        end

        assign gr_q[i*CNT_W +: CNT_W] = gr_r;

        // R3
        cap_load_chk: assert property (@(posedge clk) disable iff (rst)
            (ic_mode[i] && cap_stb[i]) |=> (gr_q[i*CNT_W +: CNT_W] == $past(cnt_val)));
    end

endmodule

// File: rtl/tmr_rd_qual.sv
module tmr_rd_qual
    import tmr_flag_pkg::*;
#(
    parameter int NUM_GR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sr_rd,
    input  logic              sr_wr,
    input  logic [NUM_GR-1:0] sr_wdata,
    input  logic [NUM_GR-1:0] flags,
    output logic [NUM_GR-1:0] clr_sw
);

    logic [NUM_GR-1:0] armed_q;

    // A read records which flags it returned as 1. A write uses them up.
    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= '0;
        else if (sr_wr)
            armed_q <= '0;
        else if (sr_rd)
            armed_q <= flags;
    end

    for (genvar i = 0; i < NUM_GR; i++) begin : g_clr
        assign clr_sw[i] = sr_wr && !sr_wdata[i] && armed_q[i];
    end

    // R5
    qual_consume_chk: assert property (@(posedge clk) disable iff (rst)
        sr_wr |=> (armed_q == '0));

endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell
    import tmr_flag_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  flag_evt_t evt,
    output logic      flag_q
);

    always_ff @(posedge clk) begin
        if (rst || !PRESENT)
            flag_q <= 1'b0;
        else
            flag_q <= flag_next(flag_q, evt);
    end

    if (PRESENT) begin : g_chk
        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            evt.set_ev |=> flag_q);

        // R5
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (flag_q && !evt.clr_sw && !evt.clr_xfer) |=> flag_q);

        // R6
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
            (!flag_q && !evt.set_ev) |=> !flag_q);
    end

endmodule

// File: rtl/tmr_cc_flags.sv
module tmr_cc_flags
    import tmr_flag_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_GR     = 3,
    parameter bit HAS_FLAG_C = 1'b1,
    parameter int SEL_W      = (NUM_GR > 1) ? $clog2(NUM_GR) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        cnt_val,
    input  logic [NUM_GR-1:0]       ic_mode,
    input  logic [NUM_GR-1:0]       cap_stb,
    input  logic                    gr_we,
    input  logic [SEL_W-1:0]        gr_sel,
    input  logic [CNT_W-1:0]        gr_wdata,
    output logic [NUM_GR*CNT_W-1:0] gr_q,
    input  logic                    sr_rd,
    input  logic                    sr_wr,
    input  logic [NUM_GR-1:0]       sr_wdata,
    output logic [NUM_GR-1:0]       sr_rdata,
    input  logic [NUM_GR-1:0]       xfer_ack,
    input  logic                    xfer_keep,
    input  logic [NUM_GR-1:0]       irq_en,
    output logic [NUM_GR-1:0]       irq
);

    logic [NUM_GR-1:0] cap_hit;
    logic [NUM_GR-1:0] cmp_hit;
    logic [NUM_GR-1:0] clr_sw;
    logic [NUM_GR-1:0] flags;

    tmr_gr_bank #(
        .CNT_W (CNT_W),
        .NUM_GR(NUM_GR),
        .SEL_W (SEL_W)
    ) gr_bank_i (
        .clk     (clk),
        .rst     (rst),
        .cnt_val (cnt_val),
        .ic_mode (ic_mode),
        .cap_stb (cap_stb),
        .gr_we   (gr_we),
        .gr_sel  (gr_sel),
        .gr_wdata(gr_wdata),
        .gr_q    (gr_q),
        .cap_hit (cap_hit),
        .cmp_hit (cmp_hit)
    );

    tmr_rd_qual #(
        .NUM_GR(NUM_GR)
    ) rd_qual_i (
        .clk     (clk),
        .rst     (rst),
        .sr_rd   (sr_rd),
        .sr_wr   (sr_wr),
        .sr_wdata(sr_wdata),
        .flags   (flags),
        .clr_sw  (clr_sw)
    );

    for (genvar i = 0; i < NUM_GR; i++) begin : g_flag
        localparam bit PRES = flag_present(i, HAS_FLAG_C);
        flag_evt_t evt;

        assign evt.set_ev   = cap_hit[i] || cmp_hit[i];
        assign evt.clr_sw   = clr_sw[i];
        assign evt.clr_xfer = xfer_ack[i] && !xfer_keep;

        tmr_flag_cell #(
            .PRESENT(PRES)
        ) cell_i (
            .clk   (clk),
            .rst   (rst),
            .evt   (evt),
            .flag_q(flags[i])
        );

        if (PRES) begin : g_chk
            // R2
            cmp_flag_chk: assert property (@(posedge clk) disable iff (rst)
                (!ic_mode[i] && (cnt_val == gr_q[i*CNT_W +: CNT_W])) |=> flags[i]);

            // R7
            keep_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (flags[i] && xfer_ack[i] && xfer_keep && !sr_wr) |=> flags[i]);
        end
    end

    assign sr_rdata = flags;
    assign irq      = flags & irq_en;

endmodule

// File: tb/tmr_cc_flags_tb.sv
module tmr_cc_flags_tb_top;

    localparam int CW = 16;
    localparam int NG = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic [CW-1:0]   cnt_val;
    logic [NG-1:0]   ic_mode;
    logic [NG-1:0]   cap_stb;
    logic            gr_we;
    logic [1:0]      gr_sel;
    logic [CW-1:0]   gr_wdata;
    logic [NG*CW-1:0] gr_q, nc_gr_q;
    logic            sr_rd;
    logic            sr_wr;
    logic [NG-1:0]   sr_wdata;
    logic [NG-1:0]   sr_rdata, nc_rdata;
    logic [NG-1:0]   xfer_ack;
    logic            xfer_keep;
    logic [NG-1:0]   irq_en;
    logic [NG-1:0]   irq, nc_irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tmr_cc_flags #(.CNT_W(CW), .NUM_GR(NG), .HAS_FLAG_C(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .ic_mode(ic_mode), .cap_stb(cap_stb),
        .gr_we(gr_we), .gr_sel(gr_sel), .gr_wdata(gr_wdata), .gr_q(gr_q),
        .sr_rd(sr_rd), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
        .xfer_ack(xfer_ack), .xfer_keep(xfer_keep), .irq_en(irq_en), .irq(irq)
    );

    tmr_cc_flags #(.CNT_W(CW), .NUM_GR(NG), .HAS_FLAG_C(1'b0)) dut_nc_i (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .ic_mode(ic_mode), .cap_stb(cap_stb),
        .gr_we(gr_we), .gr_sel(gr_sel), .gr_wdata(gr_wdata), .gr_q(nc_gr_q),
        .sr_rd(sr_rd), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rdata(nc_rdata),
        .xfer_ack(xfer_ack), .xfer_keep(xfer_keep), .irq_en(irq_en), .irq(nc_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        sr_rd = 1'b1; cyc(); sr_rd = 1'b0;
    endtask

    task automatic do_write(input logic [NG-1:0] d);
        sr_wr = 1'b1; sr_wdata = d; cyc(); sr_wr = 1'b0; sr_wdata = '0;
    endtask

    task automatic clear_all();
        do_read();
        do_write('0);
    endtask

    task automatic capture(input logic [NG-1:0] which, input logic [CW-1:0] v);
        cnt_val = v; cap_stb = which; cyc(); cap_stb = '0;
    endtask

    task automatic write_gr(input logic [1:0] sel, input logic [CW-1:0] v);
        gr_we = 1'b1; gr_sel = sel; gr_wdata = v; cyc(); gr_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 flags", sr_rdata, 0);
        chk("R1 irq", irq, 0);
        chk("R1 gr", gr_q, 0);
    endtask

    task automatic t_compare();
        cnt_val = 16'h0100;
        write_gr(2'd0, 16'h1234);
        ic_mode[0] = 1'b0;
        cnt_val = 16'h1233; cyc();
        chk("R2 no match", sr_rdata, 3'b000);
        cnt_val = 16'h1234; cyc();
        chk("R2 match sets A (R11 bit0)", sr_rdata, 3'b001);
        cnt_val = 16'h1235; ic_mode[0] = 1'b1;
        clear_all();
        cnt_val = 16'h1234; cyc();
        chk("R3 equal in capture mode", sr_rdata, 3'b000);
    endtask

    task automatic t_capture();
        capture(3'b010, 16'h0ABC);
        chk("R3 capture loads B", gr_q[CW +: CW], 16'h0ABC);
        chk("R3 capture sets B (R11 bit1)", sr_rdata, 3'b010);
        ic_mode[2] = 1'b0;
        capture(3'b100, 16'h0777);
        chk("R3 strobe in compare ignored gr", gr_q[2*CW +: CW], 16'h0000);
        chk("R3 strobe in compare ignored flag", sr_rdata, 3'b010);
        ic_mode[2] = 1'b1;
        clear_all();
        chk("R4 cleared", sr_rdata, 3'b000);
    endtask

    task automatic t_sw_clear();
        capture(3'b001, 16'h0055);
        chk("R4 read shows A", sr_rdata, 3'b001);
        do_read();
        do_write(3'b000);
        chk("R4 write0 after read1 clears", sr_rdata, 3'b000);
    endtask

    task automatic t_no_read();
        capture(3'b001, 16'h0011);
        do_write(3'b000);
        chk("R5 write0 without read", sr_rdata, 3'b001);
        do_read();
        capture(3'b010, 16'h0022);
        do_write(3'b000);
        chk("R5 stale read keeps B", sr_rdata, 3'b010);
        do_write(3'b000);
        chk("R5 qualifier consumed", sr_rdata, 3'b010);
        clear_all();
    endtask

    task automatic t_write_one();
        do_read();
        do_write(3'b111);
        chk("R6 write1 does not set", sr_rdata, 3'b000);
        capture(3'b001, 16'h0033);
        do_read();
        do_write(3'b001);
        chk("R6 write1 does not clear", sr_rdata, 3'b001);
        clear_all();
    endtask

    task automatic t_xfer();
        capture(3'b010, 16'h0044);
        xfer_ack = 3'b010; xfer_keep = 1'b1; cyc();
        chk("R7 keep holds", sr_rdata, 3'b010);
        xfer_keep = 1'b0; cyc();
        chk("R7 ack clears", sr_rdata, 3'b000);
        xfer_ack = '0;
    endtask

    task automatic t_set_wins();
        capture(3'b001, 16'h0010);
        do_read();
        sr_wr = 1'b1; sr_wdata = '0; cap_stb = 3'b001; cnt_val = 16'h0020; cyc();
        sr_wr = 1'b0; cap_stb = '0;
        chk("R8 set beats sw clear", sr_rdata, 3'b001);
        chk("R8 value captured", gr_q[0 +: CW], 16'h0020);
        xfer_ack = 3'b001; xfer_keep = 1'b0; cap_stb = 3'b001; cyc();
        xfer_ack = '0; cap_stb = '0;
        chk("R8 set beats xfer clear", sr_rdata, 3'b001);
        clear_all();
    endtask

    task automatic t_irq();
        irq_en = 3'b101;
        capture(3'b101, 16'h0066);
        chk("R9 irq both", irq, 3'b101);
        irq_en = 3'b001; #1;
        chk("R9 irq masked", irq, 3'b001);
        clear_all();
        chk("R9 irq after clear", irq, 3'b000);
        irq_en = '0;
    endtask

    task automatic t_no_c();
        irq_en = 3'b100;
        capture(3'b100, 16'h0099);
        chk("R10 full variant sets C (R11 bit2)", sr_rdata, 3'b100);
        chk("R10 reduced bit2 reads 0", nc_rdata, 3'b000);
        chk("R10 reduced irq 0", nc_irq, 3'b000);
        ic_mode[2] = 1'b0; cnt_val = 16'h0099; cyc();
        chk("R10 reduced compare ignored", nc_rdata, 3'b000);
        ic_mode[2] = 1'b1;
        clear_all();
        irq_en = '0;
    endtask

    initial begin
        rst = 1'b1; cnt_val = '0; ic_mode = '1; cap_stb = '0;
        gr_we = 1'b0; gr_sel = '0; gr_wdata = '0;
        sr_rd = 1'b0; sr_wr = 1'b0; sr_wdata = '0;
        xfer_ack = '0; xfer_keep = 1'b0; irq_en = '0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_compare();
        t_capture();
        t_sw_clear();
        t_no_read();
        t_write_one();
        t_xfer();
        t_set_wins();
        t_irq();
        t_no_c();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule